// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a SIMD integer datapath. It treats its accumulator and two source operands as vectors of 32-bit lanes. For every lane it forms a short dot product from the matching 32-bit slice of the two sources and adds that dot product to the lane's accumulator. A 2-bit opcode picks the element format and the overflow policy.

The byte format mixes signedness. The four bytes of source A are read as unsigned and the four bytes of source B as signed. The half-word format multiplies two signed 16-bit pairs. Overflow either wraps modulo 2^32 or clamps to the signed 32-bit range.

An 8-bit lane enable decides, lane by lane, whether the new value is written. A disabled lane either keeps its accumulator or becomes zero, chosen by a fill input. A bypass input treats every lane as enabled.

The lane count is a parameter, 4 or 8. Result lanes beyond the configured count always read zero. The result is registered once, and a valid flag travels alongside it.

Top module: `dpacc_unit`

## Requirements
- R1: With op_i[0]=0 (byte format), lane j adds to accumulator lane j the sum of four products. Each product is byte k of source A slice j, taken as unsigned 0..255, times byte k of source B slice j, taken as signed -128..127, for k=0..3. Byte k sits at bits 8k+7:8k of the lane.
- R2: With op_i[0]=1 (half-word format), lane j adds two products. Each product is a signed 16-bit half of source A (bits 15:0 and bits 31:16 of the lane) times the matching signed half of source B.
- R3: With op_i[1]=0 (wrap), the lane result is the low 32 bits of the exact sum. For example, 0x7FFFFFFF+1 gives 0x80000000.
- R4: With op_i[1]=1 (clamp), a sum above 0x7FFFFFFF gives 0x7FFFFFFF, a sum below -2^31 gives 0x80000000, and any other sum is returned exactly.
- R5: With mask_bypass_i=0 and zero_fill_i=0, a lane whose lane_en_i bit is 0 returns its accumulator value unchanged.
- R6: With mask_bypass_i=0 and zero_fill_i=1, a lane whose lane_en_i bit is 0 returns zero.
- R7: With mask_bypass_i=1, every configured lane returns its computed value whatever lane_en_i holds.
- R8: With LANES=4, result bits 255:128 are zero, and lane_en_i bits 7:4 and the upper operand lanes have no effect on the output.
- R9: out_valid is in_valid delayed by exactly one clock. result_o shows the result of the inputs that were presented with in_valid=1 on the previous clock edge.
- R10: While rst is high at a clock edge, out_valid and result_o are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op_i | input | 2 | Bit 0: 0 byte format, 1 half-word format; bit 1: 0 wrap, 1 clamp |
| zero_fill_i | input | 1 | Disabled lanes: 0 keep accumulator, 1 write zero |
| mask_bypass_i | input | 1 | 1 treats all lanes as enabled |
| lane_en_i | input | 8 | Per-lane write enable, bit j for lane j |
| acc_i | input | 256 | Accumulator vector, lane j at bits 32j+31:32j |
| src_a_i | input | 256 | Source A vector (unsigned bytes or signed halves) |
| src_b_i | input | 256 | Source B vector (signed bytes or signed halves) |
| out_valid | output | 1 | result_o holds a new result |
| result_o | output | 256 | Registered result vector |

## Verification
The mask properties assume that the opcode, the fill and bypass controls, and the lane-0 accumulator are sampled together with in_valid in one cycle. They also assume that reset does not fall in the middle of a transfer. The bench therefore changes every input on the falling edge only, and it holds in_valid for one full clock per vector. Reset is raised only between vectors, after the last result has been sampled. The wide internal sum is sized so that no operand pattern can overflow it, so the stimulus deliberately pushes the extremes: 0xFF bytes against 0x80 bytes, 0x8000 halves squared, and accumulators at both signed limits.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;

    localparam int LANE_W    = 32;
    localparam int MAX_LANES = 8;
    localparam int BYTE_W    = 8;
    localparam int HALF_W    = 16;
    localparam int BYTES_PER_LANE = LANE_W / BYTE_W;
    localparam int HALVES_PER_LANE = LANE_W / HALF_W;
    // byte products are 9-bit unsigned-as-signed times 8-bit signed
    localparam int BPROD_W = 2 * BYTE_W + 1;
    // half products include 0x8000 * 0x8000 = 2^30, needing a sign guard
    localparam int HPROD_W = 2 * HALF_W + 1;
    // wide enough for a 32-bit accumulator plus four 17-bit products
    localparam int SUM_W   = LANE_W + 4;
    localparam int VEC_W   = MAX_LANES * LANE_W;

    typedef enum logic { SRC_BYTE = 1'b0, SRC_HALF = 1'b1 } src_fmt_e;
    typedef enum logic { ACC_WRAP = 1'b0, ACC_CLAMP = 1'b1 } acc_mode_e;

    // packed: acc_mode lands in bit 1, fmt in bit 0
    typedef struct packed {
        acc_mode_e acc_mode;
        src_fmt_e  fmt;
    } op_t;

    typedef struct packed {
        logic bypass;
        logic zero_fill;
    } mask_ctl_t;

    localparam logic signed [SUM_W-1:0] SAT_HI =
        {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_LO =
        {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};

    function automatic logic [LANE_W-1:0] clamp_lane(input logic signed [SUM_W-1:0] v);
        logic [LANE_W-1:0] r;
        if (v > SAT_HI)
            r = SAT_HI[LANE_W-1:0];
        else if (v < SAT_LO)
            r = SAT_LO[LANE_W-1:0];
        else
            r = v[LANE_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dpacc_products.sv
module dpacc_products
    import dpacc_pkg::*;
(
    input  src_fmt_e                 fmt,
    input  logic [LANE_W-1:0]        a_i,
    input  logic [LANE_W-1:0]        b_i,
    output logic signed [SUM_W-1:0]  dot_o
);

    logic signed [BPROD_W-1:0] bprod [BYTES_PER_LANE];
    logic signed [HPROD_W-1:0] hprod [HALVES_PER_LANE];

    // R1: A bytes zero-extended, B bytes sign-extended
    for (genvar k = 0; k < BYTES_PER_LANE; k++) begin : g_byte
        logic signed [BPROD_W-1:0] a_ext;
        logic signed [BPROD_W-1:0] b_ext;
        assign a_ext = {{(BPROD_W-BYTE_W){1'b0}}, a_i[k*BYTE_W +: BYTE_W]};
        assign b_ext = {{(BPROD_W-BYTE_W){b_i[k*BYTE_W+BYTE_W-1]}}, b_i[k*BYTE_W +: BYTE_W]};
        assign bprod[k] = a_ext * b_ext;
    end

    // R2: both halves sign-extended
    for (genvar k = 0; k < HALVES_PER_LANE; k++) begin : g_half
        logic signed [HPROD_W-1:0] a_ext;
        logic signed [HPROD_W-1:0] b_ext;
        assign a_ext = {{(HPROD_W-HALF_W){a_i[k*HALF_W+HALF_W-1]}}, a_i[k*HALF_W +: HALF_W]};
        assign b_ext = {{(HPROD_W-HALF_W){b_i[k*HALF_W+HALF_W-1]}}, b_i[k*HALF_W +: HALF_W]};
        assign hprod[k] = a_ext * b_ext;
    end

    logic signed [SUM_W-1:0] byte_sum;
    logic signed [SUM_W-1:0] half_sum;

    always_comb begin
        byte_sum = '0;
        for (int k = 0; k < BYTES_PER_LANE; k++)
            byte_sum = byte_sum + {{(SUM_W-BPROD_W){bprod[k][BPROD_W-1]}}, bprod[k]};
        half_sum = '0;
        for (int k = 0; k < HALVES_PER_LANE; k++)
            half_sum = half_sum + {{(SUM_W-HPROD_W){hprod[k][HPROD_W-1]}}, hprod[k]};
    end

    assign dot_o = (fmt == SRC_HALF) ? half_sum : byte_sum;

endmodule

// File: rtl/dpacc_lane.sv
module dpacc_lane
    import dpacc_pkg::*;
(
    input  op_t               op,
    input  logic [LANE_W-1:0] acc_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic [LANE_W-1:0] lane_o
);

    logic signed [SUM_W-1:0] dot;
    logic signed [SUM_W-1:0] acc_ext;
    logic signed [SUM_W-1:0] wide;

    dpacc_products u_prod (
        .fmt   (op.fmt),
        .a_i   (a_i),
        .b_i   (b_i),
        .dot_o (dot)
    );

    assign acc_ext = {{(SUM_W-LANE_W){acc_i[LANE_W-1]}}, acc_i};
    assign wide    = acc_ext + dot;

    // R3 wrap keeps the low bits, R4 clamp saturates the exact sum
    assign lane_o = (op.acc_mode == ACC_CLAMP) ? clamp_lane(wide) : wide[LANE_W-1:0];

endmodule

// File: rtl/dpacc_mask_sel.sv
module dpacc_mask_sel
    import dpacc_pkg::*;
#(
    parameter int LANES = 4,
    localparam int ACT_W = LANES * LANE_W
) (
    input  mask_ctl_t         ctl,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [ACT_W-1:0]  calc_i,
    input  logic [ACT_W-1:0]  acc_i,
    output logic [ACT_W-1:0]  out_o
);

    for (genvar j = 0; j < LANES; j++) begin : g_sel
        logic take;
        assign take = ctl.bypass | lane_en_i[j];
        always_comb begin
            if (take)
                out_o[j*LANE_W +: LANE_W] = calc_i[j*LANE_W +: LANE_W];
            else if (ctl.zero_fill)
                out_o[j*LANE_W +: LANE_W] = '0;
            else
                out_o[j*LANE_W +: LANE_W] = acc_i[j*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/dpacc_unit.sv
module dpacc_unit
    import dpacc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_i,
    input  logic              zero_fill_i,
    input  logic              mask_bypass_i,
    input  logic [7:0]        lane_en_i,
    input  logic [VEC_W-1:0]  acc_i,
    input  logic [VEC_W-1:0]  src_a_i,
    input  logic [VEC_W-1:0]  src_b_i,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result_o
);

    localparam int ACT_W = LANES * LANE_W;

    op_t       op;
    mask_ctl_t mctl;
    assign op   = op_t'(op_i);
    assign mctl = '{bypass: mask_bypass_i, zero_fill: zero_fill_i};

    logic [ACT_W-1:0] calc;
    logic [ACT_W-1:0] masked;
    logic [VEC_W-1:0] next_vec;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        dpacc_lane u_lane (
            .op     (op),
            .acc_i  (acc_i[j*LANE_W +: LANE_W]),
            .a_i    (src_a_i[j*LANE_W +: LANE_W]),
            .b_i    (src_b_i[j*LANE_W +: LANE_W]),
            .lane_o (calc[j*LANE_W +: LANE_W])
        );
    end

    dpacc_mask_sel #(.LANES(LANES)) u_mask (
        .ctl       (mctl),
        .lane_en_i (lane_en_i[LANES-1:0]),
        .calc_i    (calc),
        .acc_i     (acc_i[ACT_W-1:0]),
        .out_o     (masked)
    );

    if (LANES < MAX_LANES) begin : g_pad
        // R8: lanes past the configured count carry zero
        assign next_vec = {{(VEC_W-ACT_W){1'b0}}, masked};
        logic unused_upper;
        assign unused_upper = ^{acc_i[VEC_W-1:ACT_W], src_a_i[VEC_W-1:ACT_W],
                                src_b_i[VEC_W-1:ACT_W], lane_en_i[MAX_LANES-1:LANES]};

        p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
            result_o[VEC_W-1:ACT_W] == '0);
    end else begin : g_full
        assign next_vec = masked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result_o  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result_o <= next_vec;
        end
    end

    // R9: one-cycle latency of the valid flag
    p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: reset clears the output register
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && result_o == '0));

    // R5: a disabled lane keeps its accumulator in merge mode
    p_merge_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mask_bypass_i && !zero_fill_i && !lane_en_i[0])
        |=> (result_o[LANE_W-1:0] == $past(acc_i[LANE_W-1:0])));

    // R6: a disabled lane becomes zero in fill mode
    p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mask_bypass_i && zero_fill_i && !lane_en_i[0])
        |=> (result_o[LANE_W-1:0] == '0));

endmodule

// File: tb/dpacc_unit_tb.sv
module dpacc_unit_tb;

    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    op_i = '0;
    logic          zero_fill_i = 1'b0;
    logic          mask_bypass_i = 1'b1;
    logic [7:0]    lane_en_i = '0;
    logic [VW-1:0] acc_i = '0;
    logic [VW-1:0] src_a_i = '0;
    logic [VW-1:0] src_b_i = '0;
    logic          out_valid, out_valid8;
    logic [VW-1:0] result_o, result8;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpacc_unit #(.LANES(4)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .zero_fill_i(zero_fill_i), .mask_bypass_i(mask_bypass_i),
        .lane_en_i(lane_en_i), .acc_i(acc_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .out_valid(out_valid), .result_o(result_o)
    );

    dpacc_unit #(.LANES(8)) u_dut8 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .zero_fill_i(zero_fill_i), .mask_bypass_i(mask_bypass_i),
        .lane_en_i(lane_en_i), .acc_i(acc_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .out_valid(out_valid8), .result_o(result8)
    );

    // op encoding: bit0 format (0 byte, 1 half), bit1 policy (0 wrap, 1 clamp)
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] acc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TABLE [NVEC] = '{
        '{2'b00, 32'h0000_0000, 32'h0101_0101, 32'h0101_0101, 32'h0000_0004, 4'd1},
        '{2'b00, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0080, 32'hFFFF_8080, 4'd1},
        '{2'b00, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8080_8080, 32'hFFFE_0200, 4'd1},
        '{2'b00, 32'h0000_000A, 32'h0403_0201, 32'hFF02_0304, 32'h0000_0016, 4'd1},
        '{2'b01, 32'h0000_0000, 32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 4'd3},
        '{2'b11, 32'h0000_0000, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 4'd4},
        '{2'b01, 32'h0000_0064, 32'h0003_FFFE, 32'h0005_0007, 32'h0000_0065, 4'd2},
        '{2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 4'd3},
        '{2'b10, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 4'd4},
        '{2'b10, 32'h8000_0000, 32'h0000_00FF, 32'h0000_0080, 32'h8000_0000, 4'd4},
        '{2'b00, 32'h8000_0000, 32'h0000_00FF, 32'h0000_0080, 32'h7FFF_8080, 4'd3},
        '{2'b11, 32'h8000_0000, 32'h0000_7FFF, 32'h0000_8000, 32'h8000_0000, 4'd4},
        '{2'b11, 32'h0000_0005, 32'h0002_0003, 32'h0004_0005, 32'h0000_001C, 4'd2},
        '{2'b10, 32'hFFFF_FFFB, 32'h0000_0002, 32'h0000_0003, 32'h0000_0001, 4'd4}
    };

    function automatic logic [31:0] model_lane(logic [1:0] op, logic [31:0] acc,
                                               logic [31:0] a, logic [31:0] b);
        longint s;
        s = longint'($signed(acc));
        if (!op[0]) begin
            for (int k = 0; k < 4; k++)
                s = s + longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
        end else begin
            for (int k = 0; k < 2; k++)
                s = s + longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        end
        if (op[1]) begin
            if (s > 64'sd2147483647) s = 64'sd2147483647;
            if (s < -64'sd2147483648) s = -64'sd2147483648;
        end
        return s[31:0];
    endfunction

    function automatic logic [VW-1:0] model_vec(int lanes);
        logic [VW-1:0] v;
        v = '0;
        for (int j = 0; j < lanes; j++) begin
            if (mask_bypass_i || lane_en_i[j])
                v[32*j +: 32] = model_lane(op_i, acc_i[32*j +: 32],
                                           src_a_i[32*j +: 32], src_b_i[32*j +: 32]);
            else if (zero_fill_i)
                v[32*j +: 32] = '0;
            else
                v[32*j +: 32] = acc_i[32*j +: 32];
        end
        return v;
    endfunction

    task automatic check(string tag, logic [VW-1:0] got, logic [VW-1:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    function automatic logic [31:0] xs32(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [VW-1:0] exp4, exp8;
        seed = 32'h1234_5678;

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset valid", {255'd0, out_valid}, '0);
        check("R10 reset result", result_o, '0);
        rst = 1'b0;

        // Table: R1 R2 R3 R4 on every lane of both widths
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            op_i = TABLE[i].op;
            mask_bypass_i = 1'b1;
            lane_en_i = 8'h00;
            for (int j = 0; j < 8; j++) begin
                acc_i[32*j +: 32]   = TABLE[i].acc;
                src_a_i[32*j +: 32] = TABLE[i].a;
                src_b_i[32*j +: 32] = TABLE[i].b;
            end
            pulse();
            for (int j = 0; j < 8; j++) begin
                check($sformatf("R%0d table %0d lane %0d (8 lanes)", TABLE[i].req, i, j),
                      {224'd0, result8[32*j +: 32]}, {224'd0, TABLE[i].expv});
                check($sformatf("R%0d table %0d lane %0d (4 lanes)", TABLE[i].req, i, j),
                      {224'd0, result_o[32*j +: 32]},
                      (j < 4) ? {224'd0, TABLE[i].expv} : '0);
            end
        end

        // Mixed lanes, opcodes and masks against the model: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            for (int j = 0; j < 8; j++) begin
                seed = xs32(seed); acc_i[32*j +: 32]   = (i % 5 == 0) ? {seed[31], {31{~seed[31]}}} : seed;
                seed = xs32(seed); src_a_i[32*j +: 32] = seed;
                seed = xs32(seed); src_b_i[32*j +: 32] = seed;
            end
            op_i = i[1:0];
            zero_fill_i = i[2];
            mask_bypass_i = (i[4:3] == 2'b11);
            seed = xs32(seed);
            lane_en_i = seed[7:0];
            exp4 = model_vec(4);
            exp8 = model_vec(8);
            pulse();
            check($sformatf("R5 R6 R7 mixed %0d 8 lanes", i), result8, exp8);
            check($sformatf("R8 mixed %0d 4 lanes", i), result_o, exp4);
        end

        // R5: merge keeps accumulators of disabled lanes
        @(negedge clk);
        op_i = 2'b00; mask_bypass_i = 1'b0; zero_fill_i = 1'b0; lane_en_i = 8'b1010_0101;
        for (int j = 0; j < 8; j++) begin
            acc_i[32*j +: 32] = 32'h1000_0000 + j; src_a_i[32*j +: 32] = 32'h0000_0002;
            src_b_i[32*j +: 32] = 32'h0000_0003;
        end
        pulse();
        check("R5 merge lane1", {224'd0, result8[63:32]}, {224'd0, 32'h1000_0001});
        check("R5 merge lane0", {224'd0, result8[31:0]}, {224'd0, 32'h1000_0006});

        // R6: zero fill clears disabled lanes
        @(negedge clk);
        zero_fill_i = 1'b1;
        pulse();
        check("R6 zero lane1", {224'd0, result8[63:32]}, '0);
        check("R6 zero lane3", {224'd0, result8[127:96]}, '0);
        check("R6 active lane2", {224'd0, result8[95:64]}, {224'd0, 32'h1000_0008});

        // R7: bypass writes every lane even with all enables clear
        @(negedge clk);
        lane_en_i = 8'h00; mask_bypass_i = 1'b1;
        pulse();
        check("R7 bypass lane1", {224'd0, result8[63:32]}, {224'd0, 32'h1000_0007});
        check("R7 bypass lane7", {224'd0, result8[255:224]}, {224'd0, 32'h1000_000D});

        // R8: upper enable bits have no effect on the 4-lane unit
        @(negedge clk);
        mask_bypass_i = 1'b0; zero_fill_i = 1'b0; lane_en_i = 8'hF0;
        pulse();
        check("R8 upper enables ignored", result_o,
              {128'd0, 32'h1000_0003, 32'h1000_0002, 32'h1000_0001, 32'h1000_0000});

        // R9: back-to-back transfers each appear one clock later
        @(negedge clk);
        mask_bypass_i = 1'b1; op_i = 2'b01;
        acc_i[31:0] = 32'd1; src_a_i[31:0] = 32'h0001_0001; src_b_i[31:0] = 32'h0002_0002;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 first result", {224'd0, result_o[31:0]}, {224'd0, 32'd5});
        check("R9 first valid", {255'd0, out_valid}, {255'd0, 1'b1});
        acc_i[31:0] = 32'd10;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second result", {224'd0, result_o[31:0]}, {224'd0, 32'd14});
        @(negedge clk);
        check("R9 valid drops", {255'd0, out_valid}, '0);
        check("R9 result held", {224'd0, result_o[31:0]}, {224'd0, 32'd14});

        // R10: reset after traffic clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset result", result8, '0);
        check("R10 mid reset valid", {255'd0, out_valid8}, '0);
        rst = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule